// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small processor that keeps every operand on a stack held in memory. It fetches 32-bit instructions from a unified, word-addressed memory inside the block, decodes a 27-entry instruction set and executes each instruction over several clock cycles. Arithmetic, comparison and output instructions work on the stack top and the word below it. Explicit addressing appears only in the push and pop variants. These variants reach a fixed variable, a slot relative to a frame register, or a word through a pointer held in memory.

Subroutines push their return address on the same stack. A return can drop a given number of slots along with the return address, which discards arguments. Division and remainder use a shared multi-cycle signed divider. A blocking input port feeds the READ instruction. A one-cycle output strobe carries printed values. A halted flag and a sticky divide-by-zero flag complete the interface. While a loader strobe is high, the core is held idle and external logic writes the program and data words into the memory.

Top module: `stk_core`

## Requirements
- R1: After reset, halted, out_valid, in_ack and div_err are 0, the PC is 0, and both the stack register and the frame register hold SP_RESET (191 by default). The stack is empty and grows upward: a push pre-increments the stack register, so the first push lands at 192 and the stack register always addresses the top item.
- R2: While load_en is high, load_data is written to memory at load_addr on each clock, and the core returns to its R1 state (halted and div_err cleared). Execution starts at address 0 after load_en falls.
- R3: An instruction has its opcode in bits [31:24] and a 16-bit immediate in bits [15:0]. Immediates pushed as data or used as a stack adjustment are sign-extended. Memory addresses, counts and labels use the immediate's low AW bits, modulo the memory size.
- R4: Opcodes 0, 1 and 2 pop two items and push the wrapped sum, difference or low product. For the difference, the item below the top is the left operand.
- R5: Opcodes 3 (quotient) and 4 (remainder) pop the divisor (top) and the dividend (below) and push the signed result. The quotient truncates toward zero, and the remainder takes the dividend's sign.
- R6: With a zero divisor, opcode 3 pushes all ones and opcode 4 pushes the dividend. Both set div_err, which stays set until reset or load.
- R7: Opcode 5 jumps to the label. Opcodes 6, 7, 8 and 9 pop the top and jump when it is zero, nonzero, at least zero, or below zero (signed), respectively. Otherwise execution falls through.
- R8: Opcode 10 pushes the address of the following instruction and jumps to the label. Opcode 11 pops the return address into the PC, then lowers the stack register by the immediate count.
- R9: Opcodes 12 to 16 push, in order: the frame register, M[frame+imm], the sign-extended immediate, M[imm], and M[M[imm]].
- R10: Opcodes 17 to 20 pop the top into, in order: the frame register, M[frame+imm], M[imm], and M[M[imm]].
- R11: Opcode 21 exchanges the top two items. Opcode 22 copies the stack register into the frame register. Opcode 23 adds the sign-extended immediate to the stack register.
- R12: Opcode 24 waits without side effects until in_valid is high. It then asserts in_ack for that cycle and pushes in_data. Opcode 25 presents the top item on out_data with out_valid high for exactly one cycle and leaves the stack unchanged.
- R13: Opcode 26 sets halted. After that the PC is frozen and no output is produced until load or reset. Opcodes above 26 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Holds the core idle and enables memory loading |
| load_addr | input | AW | Memory word address for loading |
| load_data | input | DW | Word to write while loading |
| in_valid | input | 1 | Input word available for READ |
| in_data | input | DW | Input word |
| in_ack | output | 1 | Input word consumed this cycle |
| out_valid | output | 1 | One-cycle strobe for a printed word |
| out_data | output | DW | Printed word |
| halted | output | 1 | Core has executed STOP |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
On every cycle the assertions check four things. The output strobe never lasts two cycles and never coincides with halted. Halted, the frozen PC and div_err hold until a load. An accepted input always grows the stack by exactly one slot. The data results can only be shown by the bench's programs: the arithmetic and divider sign rules, each branch condition, the frame-relative and pointer-indirect addressing, and the return with slot drop. The bench observes these through printed values after complete instruction sequences have run.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [7:0] OP_ADD     = 8'd0;
  localparam logic [7:0] OP_SUB     = 8'd1;
  localparam logic [7:0] OP_MUL     = 8'd2;
  localparam logic [7:0] OP_DIV     = 8'd3;
  localparam logic [7:0] OP_REM     = 8'd4;
  localparam logic [7:0] OP_JMP     = 8'd5;
  localparam logic [7:0] OP_BZ      = 8'd6;
  localparam logic [7:0] OP_BNZ     = 8'd7;
  localparam logic [7:0] OP_BGE     = 8'd8;
  localparam logic [7:0] OP_BLT     = 8'd9;
  localparam logic [7:0] OP_CALL    = 8'd10;
  localparam logic [7:0] OP_RET     = 8'd11;
  localparam logic [7:0] OP_PSH_FP  = 8'd12;
  localparam logic [7:0] OP_PSH_FPO = 8'd13;
  localparam logic [7:0] OP_PSH_IMM = 8'd14;
  localparam logic [7:0] OP_PSH_VAR = 8'd15;
  localparam logic [7:0] OP_PSH_IND = 8'd16;
  localparam logic [7:0] OP_POP_FP  = 8'd17;
  localparam logic [7:0] OP_POP_FPO = 8'd18;
  localparam logic [7:0] OP_POP_VAR = 8'd19;
  localparam logic [7:0] OP_POP_IND = 8'd20;
  localparam logic [7:0] OP_SWAP    = 8'd21;
  localparam logic [7:0] OP_MOVE    = 8'd22;
  localparam logic [7:0] OP_ADJ     = 8'd23;
  localparam logic [7:0] OP_IN      = 8'd24;
  localparam logic [7:0] OP_OUT     = 8'd25;
  localparam logic [7:0] OP_HALT    = 8'd26;

  typedef enum logic [2:0] {
    S_FETCH = 3'd0,
    S_EXEC  = 3'd1,
    S_DIVW  = 3'd2,
    S_SWAP2 = 3'd3,
    S_HALT  = 3'd4
  } cstate_e;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_ir,
  input  logic [AW-1:0] ra_top,
  input  logic [AW-1:0] ra_nxt,
  input  logic [AW-1:0] ra_mem,
  input  logic [AW-1:0] ra_ind,
  output logic [DW-1:0] rd_ir,
  output logic [DW-1:0] rd_top,
  output logic [DW-1:0] rd_nxt,
  output logic [DW-1:0] rd_mem,
  output logic [DW-1:0] rd_ind
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rd_ir  = words[ra_ir];
  assign rd_top = words[ra_top];
  assign rd_nxt = words[ra_nxt];
  assign rd_mem = words[ra_mem];
  assign rd_ind = words[ra_ind];
endmodule

// File: rtl/stk_div.sv
module stk_div #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dvd,
  input  logic [DW-1:0] dvs,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic          busy_q, busy_d, done_q, done_d, nq_q, nq_d, nr_q, nr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] acc_q, acc_d, qr_q, qr_d, dm_q, dm_d;
  logic [DW:0]   shifted, trial;

  assign shifted = {acc_q, qr_q[DW-1]};
  assign trial   = shifted - {1'b0, dm_q};

  always_comb begin
    busy_d = busy_q; done_d = 1'b0; nq_d = nq_q; nr_d = nr_q;
    cnt_d  = cnt_q;  acc_d  = acc_q; qr_d = qr_q; dm_d = dm_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(DW);
      acc_d  = '0;
      qr_d   = dvd[DW-1] ? -dvd : dvd;
      dm_d   = dvs[DW-1] ? -dvs : dvs;
      nq_d   = dvd[DW-1] ^ dvs[DW-1];
      nr_d   = dvd[DW-1];
    end else if (busy_q) begin
      if (!trial[DW]) begin
        acc_d = trial[DW-1:0];
        qr_d  = {qr_q[DW-2:0], 1'b1};
      end else begin
        acc_d = shifted[DW-1:0];
        qr_d  = {qr_q[DW-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; nq_q <= 1'b0; nr_q <= 1'b0;
      cnt_q  <= '0;   acc_q  <= '0;   qr_q <= '0;   dm_q <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; nq_q <= nq_d; nr_q <= nr_d;
      cnt_q  <= cnt_d;  acc_q  <= acc_d;  qr_q <= qr_d; dm_q <= dm_d;
    end
  end

  assign done = done_q;
  assign quo  = nq_q ? -qr_q : qr_q;
  assign rem  = nr_q ? -acc_q : acc_q;
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int SP_RESET = 191,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ack,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted,
  output logic          div_err
);
  localparam logic [AW-1:0] SP_INIT = AW'(SP_RESET);
  localparam int            PAD     = DW - AW;

  logic rst_sync_n;

  cstate_e       state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, sp_q, sp_d, fp_q, fp_d;
  logic [DW-1:0] ir_q, ir_d, tmp_q, tmp_d, od_q, od_d;
  logic          halted_q, halted_d, err_q, err_d, ov_q, ov_d;

  logic          c_we, m_we, div_start, div_done;
  logic [AW-1:0] c_waddr, m_waddr, ma, sp_up, sp_dn;
  logic [DW-1:0] c_wdata, m_wdata, simm;
  logic [DW-1:0] rd_ir, rd_top, rd_nxt, rd_mem, rd_ind, quo, rem;
  logic [7:0]    opc;
  logic [15:0]   imm;
  logic [AW-1:0] iaddr;
  logic          unused_ok;

  stk_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign opc       = ir_q[31:24];
  assign imm       = ir_q[15:0];
  assign iaddr     = imm[AW-1:0];
  assign simm      = {{(DW-16){imm[15]}}, imm};
  assign unused_ok = ^ir_q[23:16];
  assign sp_up     = sp_q + 1'b1;
  assign sp_dn     = sp_q - 1'b1;
  assign ma        = (opc == OP_PSH_FPO || opc == OP_POP_FPO) ? fp_q + iaddr : iaddr;

  assign m_we    = load_en | c_we;
  assign m_waddr = load_en ? load_addr : c_waddr;
  assign m_wdata = load_en ? load_data : c_wdata;

  stk_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .ra_ir(pc_q), .ra_top(sp_q), .ra_nxt(sp_dn), .ra_mem(ma),
    .ra_ind(rd_mem[AW-1:0]),
    .rd_ir(rd_ir), .rd_top(rd_top), .rd_nxt(rd_nxt), .rd_mem(rd_mem),
    .rd_ind(rd_ind)
  );

  stk_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .start(div_start), .dvd(rd_nxt),
    .dvs(rd_top), .done(div_done), .quo(quo), .rem(rem)
  );

  // next-state logic
  always_comb begin
    state_d = state_q; pc_d = pc_q; sp_d = sp_q; fp_d = fp_q;
    ir_d = ir_q; tmp_d = tmp_q; od_d = od_q;
    halted_d = halted_q; err_d = err_q; ov_d = 1'b0;
    c_we = 1'b0; c_waddr = sp_up; c_wdata = '0;
    div_start = 1'b0; in_ack = 1'b0;

    case (state_q)
      S_FETCH: begin
        ir_d    = rd_ir;
        pc_d    = pc_q + 1'b1;
        state_d = S_EXEC;
      end
      S_EXEC: begin
        state_d = S_FETCH;
        case (opc)
          OP_ADD, OP_SUB, OP_MUL: begin
            c_we = 1'b1; c_waddr = sp_dn; sp_d = sp_dn;
            c_wdata = (opc == OP_ADD) ? rd_nxt + rd_top :
                      (opc == OP_SUB) ? rd_nxt - rd_top : rd_nxt * rd_top;
          end
          OP_DIV, OP_REM: begin
            if (rd_top == '0) begin
              c_we = 1'b1; c_waddr = sp_dn; sp_d = sp_dn; err_d = 1'b1;
              c_wdata = (opc == OP_DIV) ? '1 : rd_nxt;
            end else begin
              div_start = 1'b1;
              state_d   = S_DIVW;
            end
          end
          OP_JMP: pc_d = iaddr;
          OP_BZ, OP_BNZ, OP_BGE, OP_BLT: begin
            sp_d = sp_dn;
            if ((opc == OP_BZ  && rd_top == '0) ||
                (opc == OP_BNZ && rd_top != '0) ||
                (opc == OP_BGE && !rd_top[DW-1]) ||
                (opc == OP_BLT && rd_top[DW-1]))
              pc_d = iaddr;
          end
          OP_CALL: begin
            c_we = 1'b1; c_wdata = {{PAD{1'b0}}, pc_q}; sp_d = sp_up; pc_d = iaddr;
          end
          OP_RET: begin
            pc_d = rd_top[AW-1:0];
            sp_d = sp_dn - iaddr;
          end
          OP_PSH_FP, OP_PSH_FPO, OP_PSH_IMM, OP_PSH_VAR, OP_PSH_IND: begin
            c_we = 1'b1; sp_d = sp_up;
            c_wdata = (opc == OP_PSH_FP)  ? {{PAD{1'b0}}, fp_q} :
                      (opc == OP_PSH_IMM) ? simm :
                      (opc == OP_PSH_IND) ? rd_ind : rd_mem;
          end
          OP_POP_FP: begin
            fp_d = rd_top[AW-1:0]; sp_d = sp_dn;
          end
          OP_POP_FPO, OP_POP_VAR, OP_POP_IND: begin
            c_we = 1'b1; c_wdata = rd_top; sp_d = sp_dn;
            c_waddr = (opc == OP_POP_IND) ? rd_mem[AW-1:0] : ma;
          end
          OP_SWAP: begin
            c_we = 1'b1; c_waddr = sp_q; c_wdata = rd_nxt;
            tmp_d = rd_top; state_d = S_SWAP2;
          end
          OP_MOVE: fp_d = sp_q;
          OP_ADJ:  sp_d = sp_q + simm[AW-1:0];
          OP_IN: begin
            if (in_valid) begin
              in_ack = 1'b1; c_we = 1'b1; c_wdata = in_data; sp_d = sp_up;
            end else begin
              state_d = S_EXEC;
            end
          end
          OP_OUT: begin
            ov_d = 1'b1; od_d = rd_top;
          end
          OP_HALT: begin
            halted_d = 1'b1; state_d = S_HALT;
          end
          default: ;
        endcase
      end
      S_DIVW: begin
        if (div_done) begin
          c_we = 1'b1; c_waddr = sp_dn; sp_d = sp_dn;
          c_wdata = (opc == OP_DIV) ? quo : rem;
          state_d = S_FETCH;
        end
      end
      S_SWAP2: begin
        c_we = 1'b1; c_waddr = sp_dn; c_wdata = tmp_q; state_d = S_FETCH;
      end
      default: state_d = S_HALT;
    endcase

    if (load_en) begin
      state_d = S_FETCH; pc_d = '0; sp_d = SP_INIT; fp_d = SP_INIT;
      halted_d = 1'b0; err_d = 1'b0; ov_d = 1'b0;
      c_we = 1'b0; div_start = 1'b0; in_ack = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_FETCH; pc_q <= '0; sp_q <= SP_INIT; fp_q <= SP_INIT;
      ir_q <= '0; tmp_q <= '0; od_q <= '0;
      halted_q <= 1'b0; err_q <= 1'b0; ov_q <= 1'b0;
    end else begin
      state_q <= state_d; pc_q <= pc_d; sp_q <= sp_d; fp_q <= fp_d;
      ir_q <= ir_d; tmp_q <= tmp_d; od_q <= od_d;
      halted_q <= halted_d; err_q <= err_d; ov_q <= ov_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign halted    = halted_q;
  assign div_err   = err_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_en,
  input logic          in_ack,
  input logic          out_valid,
  input logic          halted,
  input logic          div_err,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp
);
  p_out_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_read_push_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> (sp == $past(sp) + 1'b1));

  p_out_not_halted_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !halted);

  p_halt_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_en) |=> halted);

  p_pc_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_en) |=> $stable(pc));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_err && !load_en) |=> div_err);

  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!halted && !out_valid && !div_err));
endmodule

bind stk_core stk_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_en(load_en), .in_ack(in_ack),
  .out_valid(out_valid), .halted(halted), .div_err(div_err),
  .pc(pc_q), .sp(sp_q)
);

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NV = 25;

  // {opcode, below-top value, top value, expected printed value}
  localparam logic [103:0] VEC [NV] = '{
    {8'd0, 32'd5,          32'd7,          32'd12},
    {8'd0, 32'h7fffffff,   32'd1,          32'h80000000},
    {8'd1, 32'd10,         32'd3,          32'd7},
    {8'd1, 32'd3,          32'd10,         -32'sd7},
    {8'd2, -32'sd6,        32'd7,          -32'sd42},
    {8'd2, 32'h10000,      32'h10001,      32'h10000},
    {8'd3, 32'd7,          32'd2,          32'd3},
    {8'd3, -32'sd7,        32'd2,          -32'sd3},
    {8'd3, 32'd7,          -32'sd2,        -32'sd3},
    {8'd4, -32'sd7,        32'd2,          -32'sd1},
    {8'd4, 32'd7,          -32'sd2,        32'd1},
    {8'd3, 32'd7,          32'd0,          32'hffffffff},
    {8'd4, -32'sd7,        32'd0,          -32'sd7},
    {8'd3, 32'h80000000,   -32'sd1,        32'h80000000},
    {8'd3, 32'd100,        32'd7,          32'd14},
    {8'd4, 32'd100,        32'd7,          32'd2},
    {8'd5, 32'd0,          32'd0,          32'd2},
    {8'd6, 32'd0,          32'd0,          32'd2},
    {8'd6, 32'd5,          32'd0,          32'd1},
    {8'd7, 32'd5,          32'd0,          32'd2},
    {8'd7, 32'd0,          32'd0,          32'd1},
    {8'd8, 32'd0,          32'd0,          32'd2},
    {8'd8, -32'sd1,        32'd0,          32'd1},
    {8'd9, -32'sd1,        32'd0,          32'd2},
    {8'd9, 32'd0,          32'd0,          32'd1}
  };

  logic          clk, rst_n, load_en, in_valid;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data, in_data, out_data;
  logic          in_ack, out_valid, halted, div_err;

  int tests, fails, pa, ocnt, cyc;
  logic [DW-1:0] obuf [16];

  stk_core #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
    .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .div_err(div_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (load_en) ocnt = 0;
    else if (out_valid && ocnt < 16) begin
      obuf[ocnt] = out_data;
      ocnt = ocnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      tests = tests + 1; fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    tests = tests + 1;
    if (act !== exp_v) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic ld(input int a, input logic [31:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = AW'(a); load_data = d;
  endtask

  task automatic em(input logic [7:0] op, input logic [15:0] im);
    ld(pa, {op, 8'h00, im});
    pa = pa + 1;
  endtask

  task automatic go();
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic wait_halt(input string tag);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n = n + 1;
    end
    @(negedge clk); #1;
    check(tag, {31'd0, halted}, 32'd1);
  endtask

  task automatic feed(input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_data = v; #1;
    while (!in_ack) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; ocnt = 0; pa = 0;
    rst_n = 1'b0; load_en = 1'b1; load_addr = '0; load_data = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 halted", {31'd0, halted}, 32'd0);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 div_err", {31'd0, div_err}, 32'd0);
    check("R1 in_ack", {31'd0, in_ack}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: arithmetic, divider and branch templates
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  op;
      logic [31:0] a, b, e;
      string tag;
      op = VEC[i][103:96]; a = VEC[i][95:64]; b = VEC[i][63:32]; e = VEC[i][31:0];
      tag = (op <= 8'd2) ? "R4" : (op <= 8'd4) ? ((b == 0) ? "R6" : "R5") : "R7";
      ld(100, a); ld(101, b); pa = 0;
      if (op <= 8'd4) begin
        em(8'd15, 16'd100); em(8'd15, 16'd101); em(op, 16'd0);
        em(8'd25, 16'd0); em(8'd26, 16'd0);
      end else begin
        em(8'd15, 16'd100); em(op, 16'd5); em(8'd14, 16'd1);
        em(8'd25, 16'd0); em(8'd26, 16'd0); em(8'd14, 16'd2);
        em(8'd25, 16'd0); em(8'd26, 16'd0);
      end
      #1;
      check("R2 load clears div_err", {31'd0, div_err}, 32'd0);
      check("R2 load clears halted", {31'd0, halted}, 32'd0);
      go();
      wait_halt({tag, " halt"});
      check({tag, " count"}, ocnt, 32'd1);
      check({tag, " value"}, obuf[0], e);
      check({tag, " div_err"}, {31'd0, div_err},
            ((op == 8'd3 || op == 8'd4) && b == 0) ? 32'd1 : 32'd0);
    end

    // frame, pointer, swap and no-op program
    ld(40, 32'd77); ld(41, 32'd40); pa = 0;
    em(8'd12, 16'd0);  em(8'd25, 16'd0);
    em(8'd14, 16'd0);  em(8'd22, 16'd0); em(8'd12, 16'd0); em(8'd25, 16'd0);
    em(8'd16, 16'd41); em(8'd25, 16'd0);
    em(8'd14, 16'd5);  em(8'd20, 16'd41); em(8'd15, 16'd40); em(8'd25, 16'd0);
    em(8'd14, 16'd42); em(8'd17, 16'd0); em(8'd12, 16'd0); em(8'd25, 16'd0);
    em(8'd14, 16'hfff7); em(8'd18, 16'd1); em(8'd15, 16'd43); em(8'd25, 16'd0);
    em(8'd13, 16'd1);  em(8'd25, 16'd0);
    em(8'd14, 16'd1);  em(8'd14, 16'd2); em(8'd21, 16'd0); em(8'd1, 16'd0); em(8'd25, 16'd0);
    em(8'd19, 16'd44); em(8'd15, 16'd44); em(8'hf0, 16'd3); em(8'd25, 16'd0);
    em(8'd26, 16'd0);
    go();
    wait_halt("R13 halt");
    check("R1 R9 reset FP pushed", obuf[0], 32'd191);
    check("R11 R1 MOVE after push", obuf[1], 32'd193);
    check("R9 push indirect", obuf[2], 32'd77);
    check("R10 pop indirect", obuf[3], 32'd5);
    check("R10 R9 pop/push FP", obuf[4], 32'd42);
    check("R10 R3 pop frame-rel", obuf[5], 32'hfffffff7);
    check("R9 push frame-rel", obuf[6], 32'hfffffff7);
    check("R11 swap then sub", obuf[7], 32'd1);
    check("R13 R10 no-op opcode", obuf[8], 32'd1);
    repeat (40) @(negedge clk);
    #1;
    check("R13 no output after halt", ocnt, 32'd9);
    check("R13 halted holds", {31'd0, halted}, 32'd1);

    // subroutine program
    pa = 0;
    em(8'd14, 16'd7);  em(8'd10, 16'd12); em(8'd25, 16'd0);
    em(8'd14, 16'd5);  em(8'd10, 16'd20); em(8'd25, 16'd0);
    em(8'd23, 16'd1);  em(8'd25, 16'd0);  em(8'd23, 16'hffff); em(8'd25, 16'd0);
    em(8'd26, 16'd0);  em(8'd26, 16'd0);
    em(8'd22, 16'd0);  em(8'd13, 16'hffff); em(8'd14, 16'd3); em(8'd0, 16'd0);
    em(8'd18, 16'hffff); em(8'd11, 16'd0);
    pa = 20;
    em(8'd11, 16'd1);
    go();
    wait_halt("R8 halt");
    check("R8 call/return result", obuf[0], 32'd10);
    check("R8 return drops slots", obuf[1], 32'd10);
    check("R11 adjust up", obuf[2], 32'd5);
    check("R11 adjust down", obuf[3], 32'd10);
    check("R8 output count", ocnt, 32'd4);

    // input stall program
    pa = 0;
    em(8'd24, 16'd0); em(8'd24, 16'd0); em(8'd1, 16'd0);
    em(8'd25, 16'd0); em(8'd26, 16'd0);
    go();
    repeat (20) @(negedge clk);
    #1;
    check("R12 stall no halt", {31'd0, halted}, 32'd0);
    check("R12 stall no output", ocnt, 32'd0);
    check("R12 no ack without valid", {31'd0, in_ack}, 32'd0);
    feed(32'd50);
    feed(32'd8);
    wait_halt("R12 halt");
    check("R12 read result", obuf[0], 32'd42);
    check("R12 single strobe", ocnt, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule